// File: doc/BRIEF.md
# General-Purpose Flag Bank with Interrupt Detection

This block controls sixteen general-purpose flag pins through a small register interface. A direction register makes each pin an input or an output. The flag bits change through separate write-one-to-set and write-one-to-clear addresses. Software can therefore change any group of flags in one write without first reading the register. The interrupt enables use the same write-one scheme at their own pair of addresses.

Each input pin passes through a two-stage synchronizer before it is used. Two sensitivity registers then select how the pin is watched: it can follow its level, latch on a rising edge, or latch on either edge. For an output pin, the interrupt comes from the flag value that software wrote, so writing that flag acts as a software interrupt. A single interrupt line is the OR of every status bit whose enable is set.

Top module: `gpio_flag_bank`

## Requirements
- R1: Address 0x14 holds the direction register, where bit value 1 makes the pin an output. `pin_oe` equals this register one cycle after it is written. After reset every pin is an input.
- R2: Writing to address 0x08 sets every flag whose data bit is 1 and leaves the rest unchanged. For output pins the new value appears on `pin_out` one cycle after the write.
- R3: Writing to address 0x04 clears every flag whose data bit is 1 and leaves flags written as 0 unchanged.
- R4: Writing to address 0x00 loads the whole flag register. Reading addresses 0x00, 0x04 or 0x08 returns the status word. For an output pin the status bit is the written flag. For a level input pin it is the synchronized pin. For an edge input pin it is the latched edge bit.
- R5: The interrupt enables are set by writing ones to 0x10 and cleared by writing ones to 0x0C. Bits written as 0 are left unchanged. Both addresses read back the enable register.
- R6: A level input pin (bit 0 at 0x18) shows its pin value in the status word two clock edges after the pin changes. Writes to the clear address do not affect that status bit.
- R7: An edge input pin (bit 1 at 0x18) with bit 0 at 0x1C latches a status bit on a 0-to-1 transition, three clock edges after the pin change. The bit stays set after the pin falls. A 1-to-0 transition does not set it.
- R8: An edge input pin with bit 1 at 0x1C also latches its status bit on a 1-to-0 transition.
- R9: A latched edge bit is cleared by writing a 1 for it to 0x04. If an edge is detected in the same cycle as that clear, the bit remains set.
- R10: On an output pin the pin input is ignored. The written flag alone drives the status bit, and when that bit is enabled it raises `irq`.
- R11: `irq` is high exactly when some status bit and its enable are both 1. A status bit whose enable is 0 never raises `irq`.
- R12: Addresses 0x18 and 0x1C read back the two sensitivity registers, and 0x14 reads back the direction register. All configuration and flag registers are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte address; bits 4:2 select the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Driven flag values, zero on input pins |
| pin_oe | output | 16 | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The bench drives an edge so that it is detected in the same cycle as a write that clears the same bit. A design that gave the clear priority would lose that event. It checks that a rising-only pin ignores its falling transition while a both-edges pin latches on it. A detector with the wrong polarity or the wrong mode select would set or miss bits there. It also checks that clear writes do not affect level input pins, that pin activity does not affect output pins, and that unmasked status never reaches `irq`. A design that mixed the flag register with the synchronized pin, or that ignored the mask, would show stray status bits or a stray interrupt.

// File: rtl/gpio_flag_bank.sv
`timescale 1ns/1ps
module gpio_flag_bank #(
  parameter int NPINS = 16,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam logic [2:0] A_DAT  = 3'd0;
  localparam logic [2:0] A_CLR  = 3'd1;
  localparam logic [2:0] A_SET  = 3'd2;
  localparam logic [2:0] A_MCLR = 3'd3;
  localparam logic [2:0] A_MSET = 3'd4;
  localparam logic [2:0] A_DIR  = 3'd5;
  localparam logic [2:0] A_EDGE = 3'd6;
  localparam logic [2:0] A_BOTH = 3'd7;

  logic [2:0]       sel;
  logic             wr_dat, wr_clr, wr_set, wr_mclr, wr_mset, wr_dir, wr_edge, wr_both;
  logic [NPINS-1:0] dir, edge_sel, both_sel, msk, flg;
  logic [NPINS-1:0] s1, s2, s3;
  logic [NPINS-1:0] hit, base, flg_n, msk_n, status;

  assign sel     = bus_addr[4:2];
  assign wr_dat  = bus_we && (sel == A_DAT);
  assign wr_clr  = bus_we && (sel == A_CLR);
  assign wr_set  = bus_we && (sel == A_SET);
  assign wr_mclr = bus_we && (sel == A_MCLR);
  assign wr_mset = bus_we && (sel == A_MSET);
  assign wr_dir  = bus_we && (sel == A_DIR);
  assign wr_edge = bus_we && (sel == A_EDGE);
  assign wr_both = bus_we && (sel == A_BOTH);

  // two-stage synchronizer plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
    end

  assign hit = ~dir & edge_sel & ((s2 & ~s3) | (both_sel & ~s2 & s3));

  always_comb begin
    base = flg;
    if (wr_dat)      base = bus_wdata;
    else if (wr_set) base = flg | bus_wdata;
    else if (wr_clr) base = flg & ~bus_wdata;
    // level inputs hold no flag state; edge detection wins over a clear
    flg_n = (base & (dir | edge_sel)) | hit;
  end

  always_comb begin
    msk_n = msk;
    if (wr_mset)      msk_n = msk | bus_wdata;
    else if (wr_mclr) msk_n = msk & ~bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flg      <= '0;
      msk      <= '0;
      dir      <= '0;
      edge_sel <= '0;
      both_sel <= '0;
    end else begin
      flg <= flg_n;
      msk <= msk_n;
      if (wr_dir)  dir      <= bus_wdata;
      if (wr_edge) edge_sel <= bus_wdata;
      if (wr_both) both_sel <= bus_wdata;
    end

  assign status  = flg | (s2 & ~dir & ~edge_sel);
  assign pin_out = flg & dir;
  assign pin_oe  = dir;
  assign irq     = |(status & msk);

  always_comb
    case (sel)
      A_DAT, A_CLR, A_SET: bus_rdata = status;
      A_MCLR, A_MSET:      bus_rdata = msk;
      A_DIR:               bus_rdata = dir;
      A_EDGE:              bus_rdata = edge_sel;
      default:             bus_rdata = both_sel;
    endcase

  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pin_oe == $past(bus_wdata))); // R1
  AST_SET_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((pin_out & $past(bus_wdata & dir)) == $past(bus_wdata & dir))); // R2
  AST_CLR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pin_out & $past(bus_wdata)) == '0)); // R3
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> ((msk & $past(bus_wdata)) == $past(bus_wdata))); // R5
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_clr && !wr_dat) |=> ((flg & $past(flg & ~dir & edge_sel)) == $past(flg & ~dir & edge_sel))); // R7
  AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mclr && (bus_wdata == {NPINS{1'b1}})) |=> !irq); // R11
endmodule

// File: tb/tb_gpio_flag_bank.sv
`timescale 1ns/1ps
module tb_gpio_flag_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pins = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct { int kind; logic [15:0] exp; string tag; } item_t;
  item_t q[$];

  gpio_flag_bank dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq));

  always #2.5 clk = ~clk;

  // monitor: compares one queued expectation per cycle, 1 ns after the falling edge
  initial forever begin
    @(negedge clk);
    #1;
    if (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = {15'b0, irq};
        2: act = pin_oe;
        default: act = pin_out;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic chk(input int kind, input logic [4:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    q.push_back('{kind, e, tag});
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state (R12, R1)
    for (int a = 0; a < 8; a++) chk(0, 5'(a * 4), 16'h0000, "R12 reset reg");
    chk(1, 0, 16'h0000, "R11 reset irq");
    chk(2, 0, 16'h0000, "R1 reset all inputs");
    // configuration: 0-7 outputs, 8-9 rising, 10-11 both edges, 12-15 level
    wr(5'h14, 16'h00FF);
    chk(0, 5'h14, 16'h00FF, "R12 dir readback");
    chk(2, 0, 16'h00FF, "R1 pin_oe");
    wr(5'h18, 16'h0F00);
    wr(5'h1C, 16'h0C00);
    chk(0, 5'h18, 16'h0F00, "R12 edge readback");
    chk(0, 5'h1C, 16'h0C00, "R12 both readback");
    // flag set / clear / load
    wr(5'h08, 16'h0005);
    chk(3, 0, 16'h0005, "R2 set");
    wr(5'h08, 16'h0002);
    chk(3, 0, 16'h0007, "R2 set keeps others");
    wr(5'h04, 16'h0004);
    chk(3, 0, 16'h0003, "R3 clear one bit");
    wr(5'h00, 16'h00A0);
    chk(3, 0, 16'h00A0, "R4 load");
    chk(0, 5'h08, 16'h00A0, "R4 status read");
    pins = 16'h0003; idle(2);
    chk(0, 5'h00, 16'h00A0, "R10 pin ignored on outputs");
    // masks and software interrupt
    wr(5'h10, 16'h0081);
    chk(0, 5'h10, 16'h0081, "R5 mask set");
    wr(5'h0C, 16'h0001);
    chk(0, 5'h0C, 16'h0080, "R5 mask clear");
    chk(1, 0, 16'h0001, "R10 software irq");
    wr(5'h04, 16'h0080);
    chk(1, 0, 16'h0000, "R11 irq drops with flag");
    wr(5'h0C, 16'h0080);
    // level input
    wr(5'h10, 16'h1000);
    pins = 16'h1003; idle(1);
    chk(0, 5'h00, 16'h1020, "R6 level high");
    chk(1, 0, 16'h0001, "R6 level irq");
    pins = 16'h0003; idle(1);
    chk(0, 5'h00, 16'h0020, "R6 level low");
    chk(1, 0, 16'h0000, "R6 level irq off");
    pins = 16'h3003; idle(1);
    wr(5'h04, 16'h3000);
    chk(0, 5'h00, 16'h3020, "R6 clear ignored on level");
    chk(1, 0, 16'h0001, "R11 only masked level");
    pins = 16'h0003; idle(2);
    // rising edge
    wr(5'h10, 16'h0100);
    pins = 16'h0103; idle(2);
    chk(0, 5'h00, 16'h0120, "R7 rising latched");
    chk(1, 0, 16'h0001, "R7 edge irq");
    pins = 16'h0003; idle(2);
    chk(0, 5'h00, 16'h0120, "R7 sticky after fall");
    wr(5'h04, 16'h0100);
    chk(0, 5'h00, 16'h0020, "R9 clear latched");
    chk(1, 0, 16'h0000, "R9 irq cleared");
    pins = 16'h0203; idle(2);
    chk(0, 5'h00, 16'h0220, "R7 rising pin9");
    wr(5'h04, 16'h0200);
    pins = 16'h0003; idle(2);
    chk(0, 5'h00, 16'h0020, "R7 falling ignored");
    // both edges
    pins = 16'h0403; idle(2);
    chk(0, 5'h00, 16'h0420, "R8 rise");
    chk(1, 0, 16'h0000, "R11 unmasked edge quiet");
    wr(5'h04, 16'h0400);
    chk(0, 5'h00, 16'h0020, "R8 cleared");
    pins = 16'h0003; idle(2);
    chk(0, 5'h00, 16'h0420, "R8 fall latched");
    wr(5'h04, 16'h0400);
    // edge coincides with clear
    pins = 16'h0803; idle(1);
    wr(5'h04, 16'h0800);
    chk(0, 5'h00, 16'h0820, "R9 edge beats clear");
    wr(5'h04, 16'h0800);
    chk(0, 5'h00, 16'h0020, "R9 later clear");
    wr(5'h0C, 16'hFFFF);
    chk(1, 0, 16'h0000, "R11 all masked off");
    idle(3);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule